// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the burst settings of a four-bank x16 synchronous DRAM interface. It produces the column addresses of one read or write burst, one address per clock. A controller first programs the settings with a mode write. The mode word carries a burst-length code, an ordering bit and a read-latency code. The controller then issues a start command with the first column. From the clock edge that accepts the start, the block presents a valid column address on each cycle. It raises a last-beat flag on the final beat of a fixed-length burst. A stop input ends any burst early.

Columns are 9 bits wide, so one row holds 512 columns. Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. The beats run either in counting order or in exclusive-or order. In full-page mode the address counts through the whole row, wraps from 511 to 0 and keeps going until it is stopped. The controller uses the latency output to schedule read data.

The control is a three-state machine. **IDLE** moves to **LOCK** on an accepted mode write and to **BURST** on a start. **LOCK** returns to **IDLE** once the mode-write recovery time has passed, and an accepted mode write in LOCK reloads the wait. **BURST** stays in BURST on a restart (a new start) and on each ordinary beat. BURST returns to **IDLE** on a stop or after the last beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset no column is valid, the last-beat flag is low, and the settings are a burst of 1 beat, counting order, read latency 3.
- R2: A mode write is accepted only outside a burst and only when all its fields are legal. Bits 2:0 hold the length code (0→1 beat, 1→2, 2→4, 3→8, 7→full page). Bit 3 holds the ordering (0 counting, 1 exclusive-or). Bits 6:4 hold the latency code (2 or 3). An accepted write takes effect from the next cycle.
- R3: A mode write with length code 4, 5 or 6, with a latency code other than 2 or 3, or with full page combined with exclusive-or order, is rejected. A rejected write keeps every previous setting and starts no recovery wait.
- R4: A start on the clock edge right after an accepted mode write is ignored. A start on the second edge after it is accepted. When a mode write and a start are both accepted candidates on the same edge, the mode write wins.
- R5: On the edge that accepts a start, col_valid rises and col_out equals the start column for that cycle.
- R6: In counting order, beat k of a burst of length L addresses the start column's aligned block of L columns at offset ((start mod L) + k) mod L. The column bits above that block stay fixed.
- R7: In exclusive-or order, beat k of a burst of length L addresses the aligned block at offset (start mod L) XOR k.
- R8: A fixed burst gives exactly L valid beats. col_last is high only on the final beat, and col_valid falls on the cycle after the final beat.
- R9: A full-page burst steps by one column per cycle, wraps from 511 to 0, never raises col_last, and runs until stopped.
- R10: A stop sampled during a burst makes col_valid low from the next cycle. Stop takes precedence over a start on the same edge. A stop outside a burst has no effect.
- R11: A start sampled during a burst (with no stop) restarts the burst at the new column, beginning again at beat 0.
- R12: A mode write sampled during a burst is ignored. The burst continues and the settings stay unchanged.
- R13: rd_latency always shows the programmed read latency, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write request |
| mode_word | input | 7 | Mode word: length code, ordering bit, latency code |
| start | input | 1 | Start a burst |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | End the current burst |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat |
| col_last | output | 1 | Current beat is the final beat of a fixed burst |
| rd_latency | output | 2 | Programmed read latency in clocks |

## Verification
Every result appears in the first cycle after the edge that sampled its cause. A start gives its first column one cycle later. A stop or the final beat drops col_valid one cycle later. A mode write changes rd_latency one cycle later and blocks a start only on the edge that follows. The bench drives inputs just after a rising edge and advances a behavioural model on the same edge that the design uses. It compares every output at the falling edge, which is half a cycle after the result is due. The lockout, rejection and reset cases also get explicit checks at that point.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCK  = 2'd1,
        ST_BURST = 2'd2
    } bst_state_t;

    typedef struct packed {
        logic       full_page;
        logic [1:0] len_log2;
        logic       interleave;
        logic [1:0] latency;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{
        full_page:  1'b0,
        len_log2:   2'd0,
        interleave: 1'b0,
        latency:    2'd3
    };

    localparam logic [2:0] LEN_CODE_FULL = 3'd7;
    localparam logic [2:0] LAT_CODE_MIN  = 3'd2;
    localparam logic [2:0] LAT_CODE_MAX  = 3'd3;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import sdr_burst_pkg::*;
#(
    parameter int MODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] word,
    output burst_cfg_t        cfg,
    output logic              accept
);
    localparam int LEN_LSB  = 0;
    localparam int TYPE_BIT = 3;
    localparam int LAT_LSB  = 4;

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       order_bit;
    logic       len_ok;
    logic       lat_ok;
    logic       combo_ok;
    burst_cfg_t decoded;

    always_comb begin
        len_code  = word[LEN_LSB +: 3];
        lat_code  = word[LAT_LSB +: 3];
        order_bit = word[TYPE_BIT];
        len_ok    = (len_code[2] == 1'b0) || (len_code == LEN_CODE_FULL);
        lat_ok    = (lat_code == LAT_CODE_MIN) || (lat_code == LAT_CODE_MAX);
        combo_ok  = !((len_code == LEN_CODE_FULL) && order_bit);
        accept    = wr_en && len_ok && lat_ok && combo_ok;

        decoded.full_page  = (len_code == LEN_CODE_FULL);
        decoded.len_log2   = len_code[1:0];
        decoded.interleave = order_bit;
        decoded.latency    = lat_code[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (accept) begin
            cfg <= decoded;
        end
    end

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(cfg));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [COL_W-1:0] beat
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clear) begin
            beat <= '0;
        end else if (advance) begin
            beat <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col,
    output logic             at_last
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_xor;

    always_comb begin
        if (cfg.full_page) begin
            mask = '1;
        end else begin
            mask = ~({COL_W{1'b1}} << cfg.len_log2);
        end
        low_seq = (base_col + beat) & mask;
        low_xor = (base_col ^ beat) & mask;
        col     = (base_col & ~mask) | (cfg.interleave ? low_xor : low_seq);
        at_last = !cfg.full_page && (beat == mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W      = 9,
    parameter int MODE_W     = 7,
    parameter int MRD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        rd_latency
);
    localparam int LOCK_W = $clog2(MRD_CYCLES + 1);
    localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(MRD_CYCLES - 1);

    bst_state_t       state;
    bst_state_t       state_nxt;
    burst_cfg_t       cfg;
    logic             mode_try;
    logic             mode_acc;
    logic             start_take;
    logic             beat_adv;
    logic             at_last;
    logic [LOCK_W-1:0] lock_cnt;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] calc_col;

    assign mode_try = mode_wr && (state != ST_BURST);

    burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_try),
        .word   (mode_word),
        .cfg    (cfg),
        .accept (mode_acc)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_take),
        .advance (beat_adv),
        .beat    (beat)
    );

    burst_col_calc #(.COL_W(COL_W)) u_calc (
        .base_col (base_col),
        .beat     (beat),
        .cfg      (cfg),
        .col      (calc_col),
        .at_last  (at_last)
    );

    // Next-state and transition decode
    always_comb begin
        state_nxt  = state;
        start_take = 1'b0;
        beat_adv   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mode_acc) begin
                    state_nxt = ST_LOCK;
                end else if (start && !stop) begin
                    state_nxt  = ST_BURST;
                    start_take = 1'b1;
                end
            end
            ST_LOCK: begin
                if (mode_acc) begin
                    state_nxt = ST_LOCK;
                end else if (lock_cnt <= LOCK_W'(1)) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (stop) begin
                    state_nxt = ST_IDLE;
                end else if (start) begin
                    start_take = 1'b1;
                end else if (at_last) begin
                    state_nxt = ST_IDLE;
                end else begin
                    beat_adv = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_cnt <= '0;
            base_col <= '0;
        end else begin
            if (mode_acc) begin
                lock_cnt <= LOCK_LOAD;
            end else if ((state == ST_LOCK) && (lock_cnt != '0)) begin
                lock_cnt <= lock_cnt - 1'b1;
            end
            if (start_take) begin
                base_col <= start_col;
            end
        end
    end

    // Outputs
    always_comb begin
        col_valid  = (state == ST_BURST);
        col_out    = calc_col;
        col_last   = col_valid && at_last;
        rd_latency = cfg.latency;
    end

    // R5
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_take |=> (col_valid && (col_out == $past(start_col))));

    // R4
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_acc |=> !col_valid ##1 !col_valid);

    // R8
    after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start && !stop) |=> !col_valid);

    // R10
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !col_valid);

    // R9
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && cfg.full_page && !start && !stop)
            |=> (col_valid && (col_out == $past(col_out) + 1'b1)));

    // R12
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> $stable(cfg));

    // R13
    latency_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latency == 2'd2) || (rd_latency == 2'd3));

endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [6:0] mode_word = '0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic       stop = 1'b0;
    logic [8:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic [1:0] rd_latency;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    burst_col_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_word  (mode_word),
        .start      (start),
        .start_col  (start_col),
        .stop       (stop),
        .col_out    (col_out),
        .col_valid  (col_valid),
        .col_last   (col_last),
        .rd_latency (rd_latency)
    );

    // ---------------- reference model ----------------
    int m_bl = 1;
    bit m_il = 0;
    bit m_full = 0;
    int m_cl = 3;
    bit m_active = 0;
    int m_lock = 0;
    int m_first = 0;
    bit m_lock_now = 0;
    int q[$];

    function automatic bit legal_word(logic [6:0] w);
        int lc = int'(w[2:0]);
        int cc = int'(w[6:4]);
        bit len_ok = (lc <= 3) || (lc == 7);
        bit lat_ok = (cc == 2) || (cc == 3);
        return len_ok && lat_ok && !((lc == 7) && w[3]);
    endfunction

    function automatic void load(int c);
        int blk;
        int n;
        int base;
        int off;
        q.delete();
        m_active = 1;
        m_first = c;
        blk = m_full ? 512 : m_bl;
        n = blk;
        base = c - (c % blk);
        for (int k = 0; k < n; k++) begin
            if (m_il) off = (c % blk) ^ k;
            else      off = ((c % blk) + k) % blk;
            q.push_back(base + off);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bl = 1; m_il = 0; m_full = 0; m_cl = 3;
            m_active = 0; m_lock = 0; q.delete();
        end else if (mode_wr && !m_active && legal_word(mode_word)) begin
            m_full = (mode_word[2:0] == 3'd7);
            m_bl = m_full ? 512 : (1 << mode_word[1:0]);
            m_il = mode_word[3];
            m_cl = int'(mode_word[6:4]);
            m_lock = 1;
        end else begin
            m_lock_now = (m_lock > 0);
            if (m_lock_now) m_lock--;
            if (m_active) begin
                if (stop) begin
                    m_active = 0;
                    q.delete();
                end else if (start) begin
                    load(int'(start_col));
                end else begin
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        if (m_full) load(m_first);
                        else        m_active = 0;
                    end
                end
            end else if (!m_lock_now && start && !stop) begin
                load(int'(start_col));
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle compare, half a cycle after each edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_last;
            exp_last = m_active && !m_full && (q.size() == 1);
            check(col_valid == m_active, cur_req, "col_valid", int'(col_valid), int'(m_active));
            check(col_last == exp_last, cur_req, "col_last", int'(col_last), int'(exp_last));
            if (m_active && q.size() > 0)
                check(int'(col_out) == q[0], cur_req, "col_out", int'(col_out), q[0]);
            check(int'(rd_latency) == m_cl, "R13", "rd_latency", int'(rd_latency), m_cl);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_mode(logic [6:0] w);
        mode_wr = 1'b1; mode_word = w;
        tick(1);
        mode_wr = 1'b0;
    endtask

    task automatic kick(logic [8:0] c);
        start = 1'b1; start_col = c;
        tick(1);
        start = 1'b0;
    endtask

    task automatic halt();
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        @(negedge clk);
        // R1 reset state
        check(col_valid == 1'b0, "R1", "reset col_valid", int'(col_valid), 0);
        check(col_last == 1'b0, "R1", "reset col_last", int'(col_last), 0);
        check(rd_latency == 2'd3, "R1", "reset rd_latency", int'(rd_latency), 3);
        tick(1);
        cur_req = "R1 R5";
        kick(9'd5);
        tick(3);

        // R2 R4: 4 beats, counting, latency 2; start right after write ignored
        cur_req = "R4";
        write_mode(7'h22);
        kick(9'h1E6);
        @(negedge clk);
        check(col_valid == 1'b0, "R4", "start in lockout", int'(col_valid), 0);
        check(rd_latency == 2'd2, "R2", "latency after write", int'(rd_latency), 2);
        tick(1);
        cur_req = "R6 R8";
        kick(9'h1E6);
        tick(6);

        // R4: start exactly on second edge after write
        cur_req = "R4";
        write_mode(7'h22);
        tick(1);
        kick(9'h003);
        @(negedge clk);
        check(col_valid == 1'b1, "R4", "start after lockout", int'(col_valid), 1);
        tick(5);

        // R7: 8 beats, exclusive-or order
        cur_req = "R7 R8";
        write_mode(7'h3B);
        tick(2);
        kick(9'h0A5);
        tick(10);
        cur_req = "R7";
        write_mode(7'h39);
        tick(2);
        kick(9'h133);
        tick(4);

        // R3: rejected words, no lockout
        cur_req = "R3";
        write_mode(7'h34);
        kick(9'h047);
        @(negedge clk);
        check(col_valid == 1'b1, "R3", "no lockout after reject", int'(col_valid), 1);
        tick(4);
        write_mode(7'h12);
        tick(1);
        write_mode(7'h3F);
        tick(1);
        @(negedge clk);
        check(rd_latency == 2'd3, "R3", "latency kept", int'(rd_latency), 3);
        tick(1);
        kick(9'h0F0);
        tick(4);

        // R10: stop mid burst, stop with start, stop when idle
        cur_req = "R10";
        write_mode(7'h33);
        tick(2);
        kick(9'h020);
        tick(2);
        halt();
        @(negedge clk);
        check(col_valid == 1'b0, "R10", "stop mid burst", int'(col_valid), 0);
        tick(1);
        kick(9'h030);
        tick(1);
        stop = 1'b1; start = 1'b1; start_col = 9'h055;
        tick(1);
        stop = 1'b0; start = 1'b0;
        @(negedge clk);
        check(col_valid == 1'b0, "R10", "stop beats start", int'(col_valid), 0);
        tick(1);
        halt();
        tick(2);

        // R11: restart during a burst
        cur_req = "R11";
        kick(9'h010);
        tick(3);
        kick(9'h043);
        @(negedge clk);
        check(int'(col_out) == 'h043, "R11", "restart column", int'(col_out), 'h043);
        tick(9);

        // R12: mode write during burst ignored
        cur_req = "R12";
        kick(9'h100);
        tick(2);
        write_mode(7'h20);
        @(negedge clk);
        check(col_valid == 1'b1, "R12", "burst continues", int'(col_valid), 1);
        check(rd_latency == 2'd3, "R12", "latency unchanged", int'(rd_latency), 3);
        tick(8);

        // R9: full page wrap and long run
        cur_req = "R9";
        write_mode(7'h37);
        tick(2);
        kick(9'h1FC);
        tick(10);
        halt();
        tick(2);
        kick(9'h100);
        tick(600);
        halt();
        tick(3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule